// File: doc/BRIEF.md
# Byte Data Memory with Pointer Indirection

This block is the byte-wide data memory of a small processor core, addressed with eight bits. Low addresses hold a handful of core registers (two 8-bit pointers and the accumulator) and a window that is passed on to peripheral registers kept outside the block. Every address from 40H upward is general-purpose RAM. Two addresses have no storage of their own. An access to one of them is carried out at the address held in the matching pointer register.

Each cycle the core presents an address, an operation code, write data and a bit index. Read data follows the address combinationally. Writes and single-bit set or clear operations take effect on the rising clock edge. A bit operation is a read-modify-write of the addressed byte within one cycle, and it follows the same indirection as a plain write. An indirect access whose pointer names one of the two indirect addresses is a null reference: it reads zero and changes nothing.

Top module: `dmem_indirect`

## Requirements
- R1: Addresses 40H to FFH are 192 bytes of RAM. All of them are zero after reset, and a byte written there reads back unchanged.
- R2: Pointer A is at 01H, pointer B is at 03H and the accumulator is at 05H. Each is an 8-bit register that is zero after reset and can be written and read back.
- R3: A read or write at 00H acts on the byte addressed by pointer A. A read or write at 02H acts on the byte addressed by pointer B.
- R4: A read at 00H or 02H returns 00H when the matching pointer holds 00H or 02H.
- R5: A write or bit operation at 00H or 02H changes no storage and raises no peripheral write when the matching pointer holds 00H or 02H.
- R6: Addresses 04H, 06H, 07H and 28H to 3FH read as 00H, ignore writes and bit operations, and never assert the peripheral select.
- R7: The op input selects the operation: 0 is idle, 1 writes wrData, 2 sets bit bitSel of the addressed byte, and 3 clears that bit. The other seven bits are left unchanged.
- R8: A bit set or clear at 00H or 02H modifies the byte addressed by the matching pointer.
- R9: For an effective address from 08H to 27H, periphSel is high, periphAddr carries that address and rdData equals periphRdData. For ops 1 to 3, periphWrEn is high for that cycle and periphWrData holds the new byte value. periphWrEn stays low for every other access.
- R10: Storage changes only on a rising clock edge with a non-idle op. An idle cycle leaves every byte unchanged, whatever wrData holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Core address |
| op | input | 2 | Operation: 0 idle, 1 write, 2 bit set, 3 bit clear |
| wrData | input | 8 | Byte to write when op is 1 |
| bitSel | input | 3 | Bit index used by a set or clear |
| rdData | output | 8 | Byte at the effective address |
| periphSel | output | 1 | Effective address is in the peripheral window |
| periphAddr | output | 8 | Effective address sent to the peripheral port |
| periphWrEn | output | 1 | Write strobe for the peripheral port |
| periphWrData | output | 8 | New byte value for the peripheral port |
| periphRdData | input | 8 | Byte returned by the peripheral port |

## Verification
The hardest case to reach is a null reference. The core must first load a pointer with 00H or 02H through its direct address. Only then can it access the indirect address that uses that pointer, and the write that follows must be shown to have no effect anywhere. The bench therefore loads each pointer with each of the two self-referencing values. It then issues writes and bit operations through the indirect address and reads back both pointers, the accumulator and the peripheral strobe. Pointer sweeps across RAM, the accumulator and the peripheral window cover normal indirection in the same way.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int BW = $clog2(DW);

  localparam logic [AW-1:0] IND_A_ADDR = 8'h00;
  localparam logic [AW-1:0] PTR_A_ADDR = 8'h01;
  localparam logic [AW-1:0] IND_B_ADDR = 8'h02;
  localparam logic [AW-1:0] PTR_B_ADDR = 8'h03;
  localparam logic [AW-1:0] ACC_ADDR   = 8'h05;

  typedef enum logic [2:0] {
    RG_NONE, RG_PTRA, RG_PTRB, RG_ACC, RG_PERIPH, RG_RAM
  } region_e;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0, OP_WRITE = 2'd1, OP_SET = 2'd2, OP_CLR = 2'd3
  } op_e;

  typedef struct packed {
    region_e       region;
    logic [AW-1:0] effAddr;
    logic          wrStb;
    logic          setStb;
    logic          clrStb;
  } ctrl_t;
endpackage

// File: rtl/dmem_ctrl.sv
module dmem_ctrl
  import dmem_pkg::*;
#(
  parameter logic [AW-1:0] PERIPH_LO = 8'h08,
  parameter logic [AW-1:0] PERIPH_HI = 8'h27,
  parameter logic [AW-1:0] GP_BASE   = 8'h40
) (
  input  logic [AW-1:0] addr,
  input  op_e           op,
  input  logic [AW-1:0] ptrA,
  input  logic [AW-1:0] ptrB,
  output ctrl_t         ctrl
);
  logic          isInd;
  logic          nullRef;
  logic [AW-1:0] eff;

  always_comb begin
    isInd   = (addr == IND_A_ADDR) || (addr == IND_B_ADDR);
    eff     = (addr == IND_A_ADDR) ? ptrA : (addr == IND_B_ADDR) ? ptrB : addr;
    nullRef = isInd && ((eff == IND_A_ADDR) || (eff == IND_B_ADDR));

    ctrl.effAddr = eff;
    if (nullRef)                                 ctrl.region = RG_NONE;
    else if (eff >= GP_BASE)                     ctrl.region = RG_RAM;
    else if (eff >= PERIPH_LO && eff <= PERIPH_HI) ctrl.region = RG_PERIPH;
    else if (eff == PTR_A_ADDR)                  ctrl.region = RG_PTRA;
    else if (eff == PTR_B_ADDR)                  ctrl.region = RG_PTRB;
    else if (eff == ACC_ADDR)                    ctrl.region = RG_ACC;
    else                                         ctrl.region = RG_NONE;

    ctrl.wrStb  = (op == OP_WRITE);
    ctrl.setStb = (op == OP_SET);
    ctrl.clrStb = (op == OP_CLR);
  end
endmodule

// File: rtl/dmem_dp.sv
module dmem_dp
  import dmem_pkg::*;
#(
  parameter logic [AW-1:0] GP_BASE = 8'h40
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_t         ctrl,
  input  logic [DW-1:0] wrData,
  input  logic [BW-1:0] bitSel,
  input  logic [DW-1:0] periphRdData,
  output logic [DW-1:0] rdData,
  output logic [AW-1:0] ptrA,
  output logic [AW-1:0] ptrB,
  output logic [DW-1:0] acc,
  output logic          periphSel,
  output logic [AW-1:0] periphAddr,
  output logic          periphWrEn,
  output logic [DW-1:0] periphWrData
);
  localparam int RAM_DEPTH = (1 << AW) - int'(GP_BASE);

  logic [DW-1:0] ram [RAM_DEPTH];
  logic [AW-1:0] ramOff;
  logic [DW-1:0] curVal;
  logic [DW-1:0] newVal;
  logic [DW-1:0] bitMask;
  logic          commit;

  always_comb begin
    ramOff  = ctrl.effAddr - GP_BASE;
    bitMask = DW'(1) << bitSel;
    case (ctrl.region)
      RG_PTRA:   curVal = ptrA;
      RG_PTRB:   curVal = ptrB;
      RG_ACC:    curVal = acc;
      RG_PERIPH: curVal = periphRdData;
      RG_RAM:    curVal = ram[ramOff];
      default:   curVal = '0;
    endcase
    if (ctrl.wrStb)       newVal = wrData;
    else if (ctrl.setStb) newVal = curVal | bitMask;
    else                  newVal = curVal & ~bitMask;
    commit = ctrl.wrStb || ctrl.setStb || ctrl.clrStb;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrA <= '0;
      ptrB <= '0;
      acc  <= '0;
      for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= '0;
    end else if (commit) begin
      case (ctrl.region)
        RG_PTRA: ptrA <= newVal;
        RG_PTRB: ptrB <= newVal;
        RG_ACC:  acc  <= newVal;
        RG_RAM:  ram[ramOff] <= newVal;
        default: ;
      endcase
    end
  end

  assign rdData       = curVal;
  assign periphSel    = (ctrl.region == RG_PERIPH);
  assign periphAddr   = ctrl.effAddr;
  assign periphWrEn   = periphSel && commit;
  assign periphWrData = newVal;
endmodule

// File: rtl/dmem_indirect.sv
module dmem_indirect
  import dmem_pkg::*;
#(
  parameter logic [AW-1:0] PERIPH_LO = 8'h08,
  parameter logic [AW-1:0] PERIPH_HI = 8'h27,
  parameter logic [AW-1:0] GP_BASE   = 8'h40
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    op,
  input  logic [DW-1:0] wrData,
  input  logic [BW-1:0] bitSel,
  output logic [DW-1:0] rdData,
  output logic          periphSel,
  output logic [AW-1:0] periphAddr,
  output logic          periphWrEn,
  output logic [DW-1:0] periphWrData,
  input  logic [DW-1:0] periphRdData
);
  ctrl_t         ctrl;
  logic [AW-1:0] ptrA;
  logic [AW-1:0] ptrB;
  logic [DW-1:0] acc;

  dmem_ctrl #(.PERIPH_LO(PERIPH_LO), .PERIPH_HI(PERIPH_HI), .GP_BASE(GP_BASE)) u_ctrl (
    .addr(addr), .op(op_e'(op)), .ptrA(ptrA), .ptrB(ptrB), .ctrl(ctrl)
  );

  dmem_dp #(.GP_BASE(GP_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrData(wrData), .bitSel(bitSel),
    .periphRdData(periphRdData), .rdData(rdData), .ptrA(ptrA), .ptrB(ptrB),
    .acc(acc), .periphSel(periphSel), .periphAddr(periphAddr),
    .periphWrEn(periphWrEn), .periphWrData(periphWrData)
  );
endmodule

// File: rtl/dmem_indirect_chk.sv
module dmem_indirect_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] addr,
  input logic [1:0] op,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic [7:0] ptrA,
  input logic [7:0] ptrB,
  input logic [7:0] acc,
  input logic       periphSel,
  input logic       periphWrEn
);
  p_null_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (((addr == 8'h00) && (ptrA == 8'h00 || ptrA == 8'h02)) ||
     ((addr == 8'h02) && (ptrB == 8'h00 || ptrB == 8'h02))) |-> (rdData == 8'h00));

  p_null_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((addr == 8'h00) && (ptrA == 8'h02) && (op != 2'd0)) |=>
      (ptrB == $past(ptrB) && ptrA == $past(ptrA) && acc == $past(acc)));

  p_unassigned_r6: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 8'h04 || addr == 8'h06 || addr == 8'h07 || (addr >= 8'h28 && addr < 8'h40))
      |-> (rdData == 8'h00 && !periphSel));

  p_acc_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((addr == 8'h05) && (op == 2'd1)) |=> (acc == $past(wrData)));

  p_wren_sel_r9: assert property (@(posedge clk) disable iff (!rstN)
    periphWrEn |-> (periphSel && op != 2'd0));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (op == 2'd0) |=> (ptrA == $past(ptrA) && ptrB == $past(ptrB) && acc == $past(acc)));
endmodule

bind dmem_indirect dmem_indirect_chk u_chk (.*);

// File: tb/test_dmem_indirect.sv
module test_dmem_indirect;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] addr = '0;
  logic [1:0] op = '0;
  logic [7:0] wrData = '0;
  logic [2:0] bitSel = '0;
  logic [7:0] rdData, periphAddr, periphWrData, periphRdData;
  logic       periphSel, periphWrEn;

  logic [7:0] mem  [256];
  logic [7:0] pmem [256];
  int nChecks = 0, nFail = 0;

  always #5 clk = ~clk;
  assign periphRdData = pmem[periphAddr];

  dmem_indirect i_dmem_indirect (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic isInd(input logic [7:0] a); return a == 8'h00 || a == 8'h02; endfunction
  function automatic logic [7:0] effOf(input logic [7:0] a);
    return a == 8'h00 ? mem[1] : a == 8'h02 ? mem[3] : a;
  endfunction
  function automatic logic isNull(input logic [7:0] a); return isInd(a) && isInd(effOf(a)); endfunction
  function automatic logic isPer(input logic [7:0] e); return e >= 8'h08 && e <= 8'h27; endfunction
  function automatic logic isUna(input logic [7:0] e);
    return e == 8'h04 || e == 8'h06 || e == 8'h07 || (e >= 8'h28 && e < 8'h40);
  endfunction
  function automatic logic [7:0] expRead(input logic [7:0] a);
    logic [7:0] e = effOf(a);
    if (isNull(a) || isUna(e)) return 8'h00;
    if (isPer(e)) return pmem[e];
    return mem[e];
  endfunction

  task automatic readAt(input logic [7:0] a, input string tag);
    @(negedge clk);
    addr = a; op = 2'd0;
    #1 chk(tag, rdData, expRead(a));
  endtask

  task automatic doOp(input logic [7:0] a, input logic [1:0] o, input logic [7:0] d,
                      input logic [2:0] b, input string tag);
    logic [7:0] e, cur, nv;
    logic live;
    @(negedge clk);
    addr = a; op = o; wrData = d; bitSel = b;
    #1;
    e = effOf(a); cur = expRead(a);
    nv = (o == 2'd1) ? d : (o == 2'd2) ? (cur | (8'h01 << b)) : (cur & ~(8'h01 << b));
    live = !isNull(a) && o != 2'd0;
    if (live && isPer(e)) begin
      chk({tag, " R9 wren"}, {7'd0, periphWrEn}, 8'h01);
      chk({tag, " R9 wdata"}, periphWrData, nv);
      chk({tag, " R9 paddr"}, periphAddr, e);
    end else chk({tag, " R9 no wren"}, {7'd0, periphWrEn}, 8'h00);
    @(posedge clk);
    if (live) begin
      if (isPer(e)) pmem[e] = nv;
      else if (!isUna(e) && !isInd(e)) mem[e] = nv;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; pmem[i] = 8'(i) ^ 8'h5A; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // Reset state (R1, R2, R6, R9)
    for (int a = 0; a < 256; a++) readAt(8'(a), "R1/R2 reset");
    // R1 RAM sweep
    for (int a = 8'h40; a < 256; a++) doOp(8'(a), 2'd1, 8'(a * 7 + 3), 3'd0, "R1 wr");
    for (int a = 8'h40; a < 256; a++) readAt(8'(a), "R1 readback");
    // R2 core registers
    doOp(8'h01, 2'd1, 8'h5C, 3'd0, "R2"); doOp(8'h03, 2'd1, 8'hA7, 3'd0, "R2");
    doOp(8'h05, 2'd1, 8'h3E, 3'd0, "R2");
    readAt(8'h01, "R2 ptrA"); readAt(8'h03, "R2 ptrB"); readAt(8'h05, "R2 acc");
    // R6 unassigned
    for (int a = 4; a < 8'h40; a++)
      if (isUna(8'(a))) begin
        doOp(8'(a), 2'd1, 8'hFF, 3'd0, "R6 wr");
        doOp(8'(a), 2'd2, 8'h00, 3'(a), "R6 set");
        readAt(8'(a), "R6 read");
        chk("R6 sel", {7'd0, periphSel}, 8'h00);
      end
    // R3 indirection over both pointers
    for (int t = 8'h40; t < 256; t += 17) begin
      doOp(8'h01, 2'd1, 8'(t), 3'd0, "R3 ptrA");
      readAt(8'h00, "R3 indA read");
      doOp(8'h00, 2'd1, 8'(t) ^ 8'h99, 3'd0, "R3 indA wr");
      readAt(8'(t), "R3 indA target");
      doOp(8'h03, 2'd1, 8'(t + 3), 3'd0, "R3 ptrB");
      readAt(8'h02, "R3 indB read");
      doOp(8'h02, 2'd1, 8'(t) ^ 8'h3C, 3'd0, "R3 indB wr");
      readAt(8'(t + 3), "R3 indB target");
    end
    doOp(8'h01, 2'd1, 8'h05, 3'd0, "R3 ptrA acc");
    doOp(8'h00, 2'd1, 8'h77, 3'd0, "R3 acc via A");
    readAt(8'h05, "R3 acc direct");
    doOp(8'h03, 2'd1, 8'h01, 3'd0, "R3 ptrB to ptrA");
    readAt(8'h02, "R3 ptrA via B");
    // R4 / R5 null references
    for (int v = 0; v < 4; v += 2) begin
      doOp(8'h01, 2'd1, 8'(v), 3'd0, "R4 ptrA");
      doOp(8'h03, 2'd1, 8'(2 - v), 3'd0, "R4 ptrB");
      readAt(8'h00, "R4 indA null"); readAt(8'h02, "R4 indB null");
      doOp(8'h00, 2'd1, 8'hAA, 3'd0, "R5 indA wr");
      doOp(8'h02, 2'd2, 8'h00, 3'd7, "R5 indB set");
      doOp(8'h00, 2'd3, 8'h00, 3'd1, "R5 indA clr");
      readAt(8'h01, "R5 ptrA kept"); readAt(8'h03, "R5 ptrB kept");
      readAt(8'h05, "R5 acc kept");
    end
    // R7 bit operations
    for (int a = 8'h40; a < 256; a += 51)
      for (int b = 0; b < 8; b++) begin
        doOp(8'(a), 2'd2, 8'h00, 3'(b), "R7 set"); readAt(8'(a), "R7 set read");
        doOp(8'(a), 2'd3, 8'h00, 3'(b), "R7 clr"); readAt(8'(a), "R7 clr read");
      end
    for (int b = 0; b < 8; b += 3) begin
      doOp(8'h05, 2'd3, 8'h00, 3'(b), "R7 acc clr"); readAt(8'h05, "R7 acc");
    end
    // R8 bit operations through pointers
    doOp(8'h03, 2'd1, 8'h80, 3'd0, "R8 ptrB");
    doOp(8'h01, 2'd1, 8'hC1, 3'd0, "R8 ptrA");
    for (int b = 0; b < 8; b++) begin
      doOp(8'h02, 2'd2, 8'h00, 3'(b), "R8 set B"); readAt(8'h80, "R8 target B");
      doOp(8'h00, 2'd3, 8'h00, 3'(b), "R8 clr A"); readAt(8'hC1, "R8 target A");
    end
    // R9 peripheral window
    for (int a = 8'h08; a <= 8'h27; a += 7) begin
      doOp(8'(a), 2'd1, 8'(a) ^ 8'hE1, 3'd0, "R9 wr");
      readAt(8'(a), "R9 read");
      chk("R9 sel", {7'd0, periphSel}, 8'h01);
      doOp(8'(a), 2'd3, 8'h00, 3'd0, "R9 clr");
      readAt(8'(a), "R9 clr read");
    end
    readAt(8'h27, "R9 top"); readAt(8'h08, "R9 bottom");
    doOp(8'h01, 2'd1, 8'h20, 3'd0, "R9 ptrA");
    doOp(8'h00, 2'd2, 8'h00, 3'd6, "R9 ind set");
    readAt(8'h20, "R9 ind result");
    // R10 idle ops
    doOp(8'h05, 2'd0, 8'hEE, 3'd0, "R10 acc"); readAt(8'h05, "R10 acc");
    doOp(8'h90, 2'd0, 8'hEE, 3'd0, "R10 ram"); readAt(8'h90, "R10 ram");
    doOp(8'h03, 2'd0, 8'hEE, 3'd0, "R10 ptr"); readAt(8'h03, "R10 ptr");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule